// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Controller

This block decides, cycle by cycle, what each leg of a bank of differential clock outputs is doing: toggling with the clock, held high, held low, or left floating. It works in the digital domain. An internal phase register toggles on every edge of `clk` and stands for the true leg of the output clock, so the complement leg rises whenever `clk_true` falls. The block does not drive analog pins. It reports a two-bit code per leg, and a pad ring or a behavioural model turns that code into drive strength and levels.

Two asynchronous request pins gate the outputs. One stops the stoppable outputs. The other powers down the whole bank. A request counts only once it has kept the same level on two successive complement-rising edges, and its release is filtered the same way. Outputs park and resume only at clock edges where no short pulse can appear. Mode bits choose whether parked legs are driven or left floating. An output-enable polarity pin, captured while reset is high, sets the sense of the per-output enable pins.

Top module: `clkout_gate`

## Requirements
- R1: While `rst` is high, every leg code is 3 (floating) and `clk_true` is 0. Leg codes are 0 toggling, 1 driven high, 2 low, 3 floating. Output i occupies bits [2i+1:2i] of `leg_true` and `leg_comp`.
- R2: Out of reset, `clk_true` changes value on every clock edge. An enabled output with no request active reports code 0 on both legs.
- R3: An output whose enable pin is inactive, or whose `out_en` bit is 0, reports code 3 on both legs one clock later. This holds whatever the request state is.
- R4: `oe_pol_in` is captured only while `rst` is high. Captured 0 makes `oe_in` active-high. Captured 1 makes it active-low. Later changes of `oe_pol_in` have no effect.
- R5: An accepted stop with `stop_float`=0 parks each stoppable output at true=1 (high), comp=2 (low).
- R6: An accepted stop with `stop_float`=1 parks each stoppable output at true=2, comp=2.
- R7: A stopped output parks on its next transition toward the parked level. A high park starts in the cycle in which `clk_true` becomes 1. A low park starts in the cycle in which `clk_true` becomes 0.
- R8: When an accepted stop is released, all stopped outputs return to code 0 in the same cycle. This happens 4 to 12 clock edges (2 to 6 output periods) after the pin changes, and `clk_true` is 1 in that cycle.
- R9: A request level seen at only one complement-rising edge (a pin pulse two clocks wide) has no effect on any output.
- R10: An accepted power-down parks every output, free-running ones included, when `clk_true` rises. With `pwrdn_float`=0 the legs are true=1, comp=3. With `pwrdn_float`=1 they are true=3, comp=3.
- R11: Power-down takes priority over stop. When both are accepted, the power-down park applies.
- R12: With `req_invert`=0 both request pins are active-low. With `req_invert`=1 both are active-high.
- R13: An output whose `free_run` bit is 1 keeps code 0 on both legs during an accepted stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one output-clock phase per edge |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_in | input | 1 | Asynchronous stop request pin |
| pwrdn_req_in | input | 1 | Asynchronous power-down request pin |
| oe_pol_in | input | 1 | Enable-pin polarity, captured during reset |
| oe_in | input | N_OUT | Per-output enable pins |
| stop_float | input | 1 | Stop park mode: 0 driven, 1 both legs low/undriven |
| pwrdn_float | input | 1 | Power-down park mode: 0 true driven high, 1 both floating |
| req_invert | input | 1 | Inverts the active level of both request pins |
| out_en | input | N_OUT | Per-output enable bits |
| free_run | input | N_OUT | 1 marks an output as ignoring stop |
| clk_true | output | 1 | True-leg phase of the output clock |
| leg_true | output | 2*N_OUT | True-leg state codes, two bits per output |
| leg_comp | output | 2*N_OUT | Complement-leg state codes, two bits per output |

## Verification
The checker assumes that `stop_float`, `pwrdn_float` and `free_run` change only while no request is accepted. It also assumes that enable inputs are not switched in the same cycle as a park or a resume. Under these assumptions, a leg leaves or re-enters the toggling code only through a park or a resume at a defined phase of `clk_true`. The stimulus applies every input change at the falling clock edge. It changes mode bits only when both request pins are idle, and it holds each setting long enough for the two-edge filter to settle before outputs are compared.

// File: rtl/clkout_gate_pkg.sv
`timescale 1ns/1ps
package clkout_gate_pkg;
  // per-leg state code seen at the ports
  typedef enum logic [1:0] {
    LEG_TOG = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2,
    LEG_HIZ = 2'd3
  } leg_e;

  // per-output park state
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_PD   = 2'd2
  } park_e;
endpackage

// File: rtl/clkout_gate_qual.sv
`timescale 1ns/1ps
// Accepts a new request level only after SAMPLES equal samples at tick edges.
module clkout_gate_qual #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic req_raw,
  output logic req_ok
);
  localparam int HW = (SAMPLES > 1) ? SAMPLES - 1 : 1;

  logic [HW-1:0] hist;
  logic          all_one;
  logic          all_zero;

  assign all_one  = req_raw & (&hist);
  assign all_zero = ~req_raw & ~(|hist);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      req_ok <= 1'b0;
    end else if (tick) begin
      if (HW > 1) hist <= {hist[HW-2:0], req_raw};
      else        hist <= req_raw;
      if (all_one)       req_ok <= 1'b1;
      else if (all_zero) req_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/clkout_gate_slice.sv
`timescale 1ns/1ps
// One output pair: park state machine and registered leg codes.
module clkout_gate_slice
  import clkout_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_tick,   // clk_true goes 0->1 at this edge
  input  logic fall_tick,   // clk_true goes 1->0 at this edge
  input  logic en,
  input  logic stoppable,
  input  logic pd_ok,
  input  logic stop_ok,
  input  logic stop_float,
  input  logic pwrdn_float,
  output leg_e leg_t,
  output leg_e leg_c
);
  park_e st, st_nx;
  leg_e  t_nx, c_nx;
  logic  stop_edge;

  // driven-high park waits for a rising edge, low park for a falling one
  assign stop_edge = stop_float ? fall_tick : rise_tick;

  always_comb begin
    st_nx = st;
    if (pd_ok) begin
      if (rise_tick) st_nx = ST_PD;
    end else if (stop_ok && stoppable) begin
      unique case (st)
        ST_RUN:  if (stop_edge) st_nx = ST_STOP;
        ST_PD:   if (rise_tick) st_nx = ST_STOP;
        default: ;
      endcase
    end else if (st != ST_RUN && rise_tick) begin
      st_nx = ST_RUN;
    end
  end

  always_comb begin
    t_nx = LEG_HIZ;
    c_nx = LEG_HIZ;
    if (en) begin
      unique case (st_nx)
        ST_RUN: begin
          t_nx = LEG_TOG;
          c_nx = LEG_TOG;
        end
        ST_STOP: begin
          t_nx = stop_float ? LEG_LO : LEG_HI;
          c_nx = LEG_LO;
        end
        ST_PD: begin
          t_nx = pwrdn_float ? LEG_HIZ : LEG_HI;
          c_nx = LEG_HIZ;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_RUN;
      leg_t <= LEG_HIZ;
      leg_c <= LEG_HIZ;
    end else begin
      st    <= st_nx;
      leg_t <= t_nx;
      leg_c <= c_nx;
    end
  end
endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate
  import clkout_gate_pkg::*;
#(
  parameter int N_OUT        = 4,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_req_in,
  input  logic               pwrdn_req_in,
  input  logic               oe_pol_in,
  input  logic [N_OUT-1:0]   oe_in,
  input  logic               stop_float,
  input  logic               pwrdn_float,
  input  logic               req_invert,
  input  logic [N_OUT-1:0]   out_en,
  input  logic [N_OUT-1:0]   free_run,
  output logic               clk_true,
  output logic [2*N_OUT-1:0] leg_true,
  output logic [2*N_OUT-1:0] leg_comp
);
  logic phase;
  logic oe_pol_q;
  logic stop_raw, pd_raw;
  logic stop_ok, pd_ok;
  logic rise_tick, fall_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      oe_pol_q <= oe_pol_in;
    end else begin
      phase    <= ~phase;
    end
  end

  assign clk_true  = phase;
  assign rise_tick = ~phase;
  assign fall_tick = phase;   // complement leg rises here: sampling point

  assign stop_raw = req_invert ? stop_req_in  : ~stop_req_in;
  assign pd_raw   = req_invert ? pwrdn_req_in : ~pwrdn_req_in;

  clkout_gate_qual #(.SAMPLES(QUAL_SAMPLES)) u_qual_stop (
    .clk(clk), .rst(rst), .tick(fall_tick), .req_raw(stop_raw), .req_ok(stop_ok)
  );

  clkout_gate_qual #(.SAMPLES(QUAL_SAMPLES)) u_qual_pd (
    .clk(clk), .rst(rst), .tick(fall_tick), .req_raw(pd_raw), .req_ok(pd_ok)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_slice
    leg_e lt, lc;
    logic en_i;
    assign en_i = (oe_in[i] ^ oe_pol_q) & out_en[i];

    clkout_gate_slice u_slice (
      .clk        (clk),
      .rst        (rst),
      .rise_tick  (rise_tick),
      .fall_tick  (fall_tick),
      .en         (en_i),
      .stoppable  (~free_run[i]),
      .pd_ok      (pd_ok),
      .stop_ok    (stop_ok),
      .stop_float (stop_float),
      .pwrdn_float(pwrdn_float),
      .leg_t      (lt),
      .leg_c      (lc)
    );

    assign leg_true[2*i +: 2] = lt;
    assign leg_comp[2*i +: 2] = lc;
  end
endmodule

// File: rtl/clkout_gate_chk.sv
`timescale 1ns/1ps
module clkout_gate_chk #(
  parameter int N_OUT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               clk_true,
  input logic [N_OUT-1:0]   out_en,
  input logic [2*N_OUT-1:0] leg_true,
  input logic [2*N_OUT-1:0] leg_comp
);
  localparam logic [1:0] C_TOG = 2'd0;
  localparam logic [1:0] C_HI  = 2'd1;
  localparam logic [1:0] C_LO  = 2'd2;
  localparam logic [1:0] C_HIZ = 2'd3;

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  assert_clk_alternates_R2: assert property (@(posedge clk) disable iff (rst)
    primed |-> (clk_true != $past(clk_true)));

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    // R7: high park begins as the true leg rises
    assert_park_high_phase_R7: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(leg_true[2*i +: 2]) == C_TOG && leg_true[2*i +: 2] == C_HI)
      |-> clk_true);

    // R7: low park begins as the true leg falls
    assert_park_low_phase_R7: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(leg_true[2*i +: 2]) == C_TOG && leg_true[2*i +: 2] == C_LO)
      |-> !clk_true);

    // R8: resumption starts with a full high phase
    assert_resume_high_R8: assert property (@(posedge clk) disable iff (rst)
      (primed && ($past(leg_true[2*i +: 2]) == C_HI || $past(leg_true[2*i +: 2]) == C_LO)
       && leg_true[2*i +: 2] == C_TOG) |-> clk_true);

    // R3: a disabled output floats on both legs
    assert_disabled_floats_R3: assert property (@(posedge clk) disable iff (rst)
      (primed && !$past(out_en[i]))
      |-> (leg_true[2*i +: 2] == C_HIZ && leg_comp[2*i +: 2] == C_HIZ));
  end
endmodule

bind clkout_gate clkout_gate_chk #(.N_OUT(N_OUT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clk_true(clk_true),
  .out_en  (out_en),
  .leg_true(leg_true),
  .leg_comp(leg_comp)
);

// File: tb/clkout_gate_test.sv
`timescale 1ns/1ps
module clkout_gate_test;
  localparam int N = 4;
  localparam logic [1:0] TOG = 2'd0;
  localparam logic [1:0] HI  = 2'd1;
  localparam logic [1:0] LO  = 2'd2;
  localparam logic [1:0] HZ  = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req_in = 1'b1, pwrdn_req_in = 1'b1, oe_pol_in = 1'b0;
  logic [N-1:0] oe_in = '1, out_en = '1, free_run = '0;
  logic stop_float = 1'b0, pwrdn_float = 1'b0, req_invert = 1'b0;
  logic clk_true;
  logic [2*N-1:0] leg_true, leg_comp;

  always #10 clk = ~clk;   // 50 MHz

  clkout_gate #(.N_OUT(N)) uut (
    .clk(clk), .rst(rst), .stop_req_in(stop_req_in), .pwrdn_req_in(pwrdn_req_in),
    .oe_pol_in(oe_pol_in), .oe_in(oe_in), .stop_float(stop_float),
    .pwrdn_float(pwrdn_float), .req_invert(req_invert), .out_en(out_en),
    .free_run(free_run), .clk_true(clk_true), .leg_true(leg_true), .leg_comp(leg_comp)
  );

  int  nchk = 0;
  int  nfail = 0;
  bit  done = 1'b0;

  typedef struct {
    logic [2*N-1:0] t;
    logic [2*N-1:0] c;
    string          tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [2*N-1:0] v4(input logic [1:0] c3, input logic [1:0] c2,
                                        input logic [1:0] c1, input logic [1:0] c0);
    return {c3, c2, c1, c0};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // monitor: pops expected leg codes and compares at a falling edge
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(leg_true == e.t, {e.tag, " true legs"}, int'(leg_true), int'(e.t));
      chk(leg_comp == e.c, {e.tag, " comp legs"}, int'(leg_comp), int'(e.c));
    end
  end

  // driver side: queue an expectation and hold inputs while it is compared
  task automatic expect_legs(input logic [2*N-1:0] t, input logic [2*N-1:0] c,
                             input string tag);
    exp_t e;
    e.t = t; e.c = c; e.tag = tag;
    sb.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits until output 0 enters (until_tog=1) or leaves (0) the toggling code
  task automatic wait_out0(input bit until_tog, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (n < 30 && ((leg_true[1:0] == TOG) != until_tog));
  endtask

  localparam logic [2*N-1:0] ALL_TOG = '0;

  initial begin
    int n;
    logic a;
    // R1: reset state
    idle(3);
    chk(leg_true == {N{HZ}} && leg_comp == {N{HZ}}, "R1 legs in reset",
        int'({leg_true, leg_comp}), int'({2{{N{HZ}}}}));
    chk(clk_true == 1'b0, "R1 clk_true in reset", int'(clk_true), 0);
    rst = 1'b0;
    idle(6);

    // R2: free running, clock alternates
    expect_legs(ALL_TOG, ALL_TOG, "R2 idle run");
    a = clk_true;
    @(negedge clk);
    chk(clk_true != a, "R2 clk_true alternates", int'(clk_true), int'(!a));

    // R3: pin and register disables
    oe_in[1] = 1'b0;  idle(2);
    expect_legs(v4(TOG, TOG, HZ, TOG), v4(TOG, TOG, HZ, TOG), "R3 pin disable");
    oe_in[1] = 1'b1;  out_en[2] = 1'b0; idle(2);
    expect_legs(v4(TOG, HZ, TOG, TOG), v4(TOG, HZ, TOG, TOG), "R3 bit disable");
    out_en[2] = 1'b1;
    // R4: polarity pin ignored after reset
    oe_pol_in = 1'b1; idle(3);
    expect_legs(ALL_TOG, ALL_TOG, "R4 polarity change after reset");
    oe_pol_in = 1'b0;

    // R5 / R7 / R13: driven stop, output 3 free-running
    free_run = 4'b1000;
    stop_req_in = 1'b0;
    wait_out0(1'b0, n);
    chk(clk_true == 1'b1, "R7 high park on rising phase", int'(clk_true), 1);
    idle(2);
    expect_legs(v4(TOG, HI, HI, HI), v4(TOG, LO, LO, LO), "R5 driven stop park");
    chk(leg_true[7:6] == TOG && leg_comp[7:6] == TOG, "R13 free-run keeps toggling",
        int'({leg_true[7:6], leg_comp[7:6]}), 0);

    // R8: resume latency, together, high phase first
    stop_req_in = 1'b1;
    wait_out0(1'b1, n);
    chk(n >= 4 && n <= 12, "R8 resume latency", n, 4);
    chk(leg_true == ALL_TOG && leg_comp == ALL_TOG, "R8 resume together",
        int'({leg_true, leg_comp}), 0);
    chk(clk_true == 1'b1, "R8 resume high phase", int'(clk_true), 1);
    idle(4);

    // R6 / R7: undriven stop
    stop_float = 1'b1;
    stop_req_in = 1'b0;
    wait_out0(1'b0, n);
    chk(clk_true == 1'b0, "R7 low park on falling phase", int'(clk_true), 0);
    idle(2);
    expect_legs(v4(TOG, LO, LO, LO), v4(TOG, LO, LO, LO), "R6 undriven stop park");
    stop_req_in = 1'b1;
    wait_out0(1'b1, n);
    chk(clk_true == 1'b1, "R8 resume from low park", int'(clk_true), 1);
    idle(4);
    stop_float = 1'b0;

    // R9: two-clock pulses are filtered out
    stop_req_in = 1'b0; idle(2); stop_req_in = 1'b1;
    pwrdn_req_in = 1'b0; idle(2); pwrdn_req_in = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(leg_true == ALL_TOG && leg_comp == ALL_TOG, "R9 short pulse ignored",
          int'({leg_true, leg_comp}), 0);
    end

    // R10: power-down, driven then floating
    pwrdn_req_in = 1'b0;
    wait_out0(1'b0, n);
    chk(clk_true == 1'b1, "R10 power-down park on rising phase", int'(clk_true), 1);
    idle(2);
    expect_legs({N{HI}}, {N{HZ}}, "R10 driven power-down");
    pwrdn_req_in = 1'b1; idle(14);
    expect_legs(ALL_TOG, ALL_TOG, "R10 power-down release");
    pwrdn_float = 1'b1;
    pwrdn_req_in = 1'b0; idle(12);
    expect_legs({N{HZ}}, {N{HZ}}, "R10 floating power-down");
    pwrdn_req_in = 1'b1; idle(14);
    expect_legs(ALL_TOG, ALL_TOG, "R10 floating release");
    pwrdn_float = 1'b0;

    // R11: power-down wins over stop
    stop_req_in = 1'b0; pwrdn_req_in = 1'b0; idle(12);
    expect_legs({N{HI}}, {N{HZ}}, "R11 power-down priority");
    pwrdn_req_in = 1'b1; idle(14);
    expect_legs(v4(TOG, HI, HI, HI), v4(TOG, LO, LO, LO), "R11 stop after power-down release");
    stop_req_in = 1'b1; idle(14);
    expect_legs(ALL_TOG, ALL_TOG, "R8 release after R11");

    // R12: inverted request polarity
    req_invert = 1'b1; stop_req_in = 1'b0; pwrdn_req_in = 1'b0; idle(12);
    expect_legs(ALL_TOG, ALL_TOG, "R12 low pins idle when inverted");
    stop_req_in = 1'b1; idle(12);
    expect_legs(v4(TOG, HI, HI, HI), v4(TOG, LO, LO, LO), "R12 high pin stops");
    stop_req_in = 1'b0; idle(14);
    expect_legs(ALL_TOG, ALL_TOG, "R12 release");
    req_invert = 1'b0; stop_req_in = 1'b1; pwrdn_req_in = 1'b1;

    // R4: active-low enables via polarity captured in reset
    rst = 1'b1; oe_pol_in = 1'b1; oe_in = '0; idle(3);
    rst = 1'b0; idle(6);
    expect_legs(ALL_TOG, ALL_TOG, "R4 active-low enables");
    oe_in = 4'b0001; idle(2);
    expect_legs(v4(TOG, TOG, TOG, HZ), v4(TOG, TOG, TOG, HZ), "R4 pin high disables");
    oe_pol_in = 1'b0; idle(3);
    expect_legs(v4(TOG, TOG, TOG, HZ), v4(TOG, TOG, TOG, HZ), "R4 polarity held");

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule